// File: doc/BRIEF.md
# Memory presence enumerator

This block works out which physical pages of a paged memory really exist, and builds a packed page table of the ones that do. A page is 256 words of 16 bits, so it holds 64 quadwords. The memory can have up to 4096 pages. Missing storage, such as the unimplemented gap on a partly populated board, returns all-ones data. A write into such a gap may alias onto a lower real page.

After a start pulse the block writes a signature quadword into quadword 0 of every page, going from the highest page down to page 0. It then reads each signature back, going upwards, and counts the bits that differ from the expected value. A page with at most three wrong bits is taken to exist, even if it is faulty. A page with more wrong bits is taken to be absent. Each existing page gets the next free page-table slot and is then cleared to zero. When every page has been examined, all the unused slots are written with a vacant marker. The block then raises done and reports how many pages it found.

Later data-pattern testing of the pages is done elsewhere. This block only enumerates the pages and prepares them.

Top module: `mem_enum`

## Requirements
- R1: After reset, `done`, `memWrite`, `memRead` and `ptWrite` are 0 and `pageCount` is 0.
- R2: A start pulse begins the signature phase. There is one write per page, in strictly descending page order from the top page down to page 0, always to quadword index 0. The data is word0 = page number (zero-extended), word1 = 0x00D6, word2 = 0xB800, word3 = 0x0000. Word k sits in `memWdata[16k+15:16k]`.
- R3: The examination phase then reads quadword 0 of each page exactly once, in ascending page order. Read data is taken from `memRdata` one cycle after `memRead` is high. A read and a write never happen in the same cycle.
- R4: The XOR of the read data with the expected signature is reduced to a count of set bits. A count below 4 marks the page as existing, so pages with 1, 2 or 3 wrong bits are kept. A count of 4 or more, including an all-ones read, marks the page as absent.
- R5: Existing pages fill page-table slots 0, 1, 2, … in ascending physical order. Each entry is the physical page number, zero-extended to 16 bits.
- R6: Right after the table write for a page, all 64 quadwords of that page are written with zero, from quadword 63 down to 0. Absent pages are never zeroed.
- R7: After the last page, every slot from `pageCount` up to the last slot is written with 0x6000 in ascending order. Across one run, each slot is written exactly once.
- R8: At the end, `pageCount` equals the number of existing pages. `done` stays high, with `pageCount` stable and no memory or table traffic, until the next start pulse.
- R9: With N pages and E existing pages, `done` first reads high after exactly 5·N + 63·E rising edges following the edge that samples start.
- R10: A signature write into a gap that aliases onto a lower real page does not hide that page. The later, lower write restores its signature.
- R11: A start pulse while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an enumeration run when idle or done |
| memWrite | output | 1 | Quadword write strobe |
| memRead | output | 1 | Quadword read strobe |
| memAddr | output | PageBits+6 | Quadword address {page, quadword index} |
| memWdata | output | 64 | Write data, word k in bits 16k+15:16k |
| memRdata | input | 64 | Read data, valid one cycle after memRead |
| ptWrite | output | 1 | Page-table write strobe |
| ptSlot | output | PageBits | Page-table slot being written |
| ptData | output | 16 | Entry: physical page number, or 0x6000 for vacant |
| done | output | 1 | Run complete |
| pageCount | output | PageBits+1 | Number of existing pages found |

## Verification
The memory model in the bench returns read data on the edge that follows `memRead`. The block registers the wrong-bit count on the next edge and makes its table write on the edge after that, so each page costs three cycles plus 64 more when it is cleared. The bench counts rising edges from the edge that samples start and samples `done` on falling edges. It expects `done` exactly 5·N + 63·E edges later, then confirms it holds for several further cycles. The table, memory contents and signature log are read from the bench's own models only after `done`, so no check depends on which process runs first at an edge.

// File: rtl/mem_enum_pkg.sv
package mem_enum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SIGWR, ST_RDREQ, ST_RDWAIT,
    ST_JUDGE, ST_ZERO, ST_FILL, ST_DONE
  } enumState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCount;
    logic pageToTop;
    logic pageDec;
    logic pageInc;
    logic qwToTop;
    logic qwToZero;
    logic qwDec;
    logic capErr;
    logic countInc;
    logic fillLoad;
    logic fillInc;
    logic selSig;
    logic selVacant;
  } dpCtrl_t;

  localparam int          QuadW     = 64;
  localparam logic [15:0] SigWord1  = 16'h00D6;
  localparam logic [15:0] SigWord2  = 16'hB800;
  localparam logic [15:0] SigWord3  = 16'h0000;
  localparam logic [15:0] VacantEnc = 16'h6000;
  localparam int          MissLimit = 4;

endpackage

// File: rtl/mem_enum_popcnt.sv
module mem_enum_popcnt #(
  parameter int Width  = 64,
  parameter int CapVal = 4,
  parameter int OutW   = 3
) (
  input  logic [Width-1:0] vecIn,
  output logic [OutW-1:0]  cntOut
);
  localparam int SumW = $clog2(Width + 1);

  logic [SumW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < Width; i++) begin
      sum = sum + SumW'(vecIn[i]);
    end
    if (sum >= SumW'(CapVal)) cntOut = OutW'(CapVal);
    else                      cntOut = OutW'(sum);
  end
endmodule

// File: rtl/mem_enum_ctrl.sv
module mem_enum_ctrl
  import mem_enum_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    pageAtTop,
  input  logic    pageAtZero,
  input  logic    qwAtZero,
  input  logic    pageExists,
  input  logic    tableFull,
  input  logic    fillAtEnd,
  output dpCtrl_t dpCtrl,
  output logic    memWrite,
  output logic    memRead,
  output logic    ptWrite,
  output logic    done
);
  enumState_t st, nxt;
  enumState_t advState;
  logic advInc, advFill;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  // where to go once the current page is finished
  always_comb begin
    advState = ST_RDREQ;
    advInc   = 1'b0;
    advFill  = 1'b0;
    if (pageAtTop) begin
      if (tableFull) advState = ST_DONE;
      else begin
        advState = ST_FILL;
        advFill  = 1'b1;
      end
    end else begin
      advInc = 1'b1;
    end
  end

  always_comb begin
    nxt      = st;
    dpCtrl   = '0;
    memWrite = 1'b0;
    memRead  = 1'b0;
    ptWrite  = 1'b0;
    unique case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          nxt               = ST_SIGWR;
          dpCtrl.pageToTop  = 1'b1;
          dpCtrl.qwToZero   = 1'b1;
          dpCtrl.clearCount = 1'b1;
        end
      end
      ST_SIGWR: begin
        memWrite      = 1'b1;
        dpCtrl.selSig = 1'b1;
        if (pageAtZero) nxt = ST_RDREQ;
        else            dpCtrl.pageDec = 1'b1;
      end
      ST_RDREQ: begin
        memRead = 1'b1;
        nxt     = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        dpCtrl.capErr = 1'b1;
        nxt           = ST_JUDGE;
      end
      ST_JUDGE: begin
        if (pageExists) begin
          ptWrite         = 1'b1;
          dpCtrl.countInc = 1'b1;
          dpCtrl.qwToTop  = 1'b1;
          nxt             = ST_ZERO;
        end else begin
          nxt             = advState;
          dpCtrl.pageInc  = advInc;
          dpCtrl.fillLoad = advFill;
        end
      end
      ST_ZERO: begin
        memWrite = 1'b1;
        if (qwAtZero) begin
          nxt             = advState;
          dpCtrl.pageInc  = advInc;
          dpCtrl.fillLoad = advFill;
        end else begin
          dpCtrl.qwDec = 1'b1;
        end
      end
      ST_FILL: begin
        ptWrite          = 1'b1;
        dpCtrl.selVacant = 1'b1;
        if (fillAtEnd) nxt = ST_DONE;
        else           dpCtrl.fillInc = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign done = (st == ST_DONE);
endmodule

// File: rtl/mem_enum_dp.sv
module mem_enum_dp
  import mem_enum_pkg::*;
#(
  parameter int PageBits = 12,
  parameter int QwBits   = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    dpCtrl,
  input  logic [QuadW-1:0]           memRdata,
  output logic [PageBits+QwBits-1:0] memAddr,
  output logic [QuadW-1:0]           memWdata,
  output logic [PageBits-1:0]        ptSlot,
  output logic [15:0]                ptData,
  output logic [PageBits:0]          pageCount,
  output logic                       pageAtTop,
  output logic                       pageAtZero,
  output logic                       qwAtZero,
  output logic                       pageExists,
  output logic                       tableFull,
  output logic                       fillAtEnd
);
  localparam int CntW = 3;

  logic [PageBits-1:0] pageReg;
  logic [QwBits-1:0]   qwReg;
  logic [PageBits:0]   countReg;
  logic [PageBits-1:0] fillReg;
  logic [CntW-1:0]     errCnt;
  logic [CntW-1:0]     errNow;
  logic [QuadW-1:0]    sigExp;

  assign sigExp = {SigWord3, SigWord2, SigWord1, 16'(pageReg)};

  mem_enum_popcnt #(.Width(QuadW), .CapVal(MissLimit), .OutW(CntW)) u_pop (
    .vecIn  (memRdata ^ sigExp),
    .cntOut (errNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      qwReg    <= '0;
      countReg <= '0;
      fillReg  <= '0;
      errCnt   <= '0;
    end else begin
      if (dpCtrl.pageToTop)    pageReg <= '1;
      else if (dpCtrl.pageDec) pageReg <= pageReg - 1'b1;
      else if (dpCtrl.pageInc) pageReg <= pageReg + 1'b1;

      if (dpCtrl.qwToTop)       qwReg <= '1;
      else if (dpCtrl.qwToZero) qwReg <= '0;
      else if (dpCtrl.qwDec)    qwReg <= qwReg - 1'b1;

      if (dpCtrl.clearCount)    countReg <= '0;
      else if (dpCtrl.countInc) countReg <= countReg + 1'b1;

      if (dpCtrl.fillLoad)     fillReg <= countReg[PageBits-1:0];
      else if (dpCtrl.fillInc) fillReg <= fillReg + 1'b1;

      if (dpCtrl.capErr) errCnt <= errNow;
    end
  end

  assign memAddr    = {pageReg, qwReg};
  assign memWdata   = dpCtrl.selSig ? sigExp : '0;
  assign ptSlot     = dpCtrl.selVacant ? fillReg : countReg[PageBits-1:0];
  assign ptData     = dpCtrl.selVacant ? VacantEnc : 16'(pageReg);
  assign pageCount  = countReg;
  assign pageAtTop  = &pageReg;
  assign pageAtZero = (pageReg == '0);
  assign qwAtZero   = (qwReg == '0);
  assign pageExists = (errCnt < CntW'(MissLimit));
  assign tableFull  = countReg[PageBits];
  assign fillAtEnd  = &fillReg;
endmodule

// File: rtl/mem_enum.sv
module mem_enum
  import mem_enum_pkg::*;
#(
  parameter int PageBits  = 12,
  parameter int PageWords = 256,
  localparam int QwBits   = $clog2(PageWords / 4),
  localparam int AddrW    = PageBits + QwBits
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                memWrite,
  output logic                memRead,
  output logic [AddrW-1:0]    memAddr,
  output logic [63:0]         memWdata,
  input  logic [63:0]         memRdata,
  output logic                ptWrite,
  output logic [PageBits-1:0] ptSlot,
  output logic [15:0]         ptData,
  output logic                done,
  output logic [PageBits:0]   pageCount
);
  dpCtrl_t dpCtrl;
  logic pageAtTop, pageAtZero, qwAtZero, pageExists, tableFull, fillAtEnd;

  mem_enum_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .pageAtTop  (pageAtTop),
    .pageAtZero (pageAtZero),
    .qwAtZero   (qwAtZero),
    .pageExists (pageExists),
    .tableFull  (tableFull),
    .fillAtEnd  (fillAtEnd),
    .dpCtrl     (dpCtrl),
    .memWrite   (memWrite),
    .memRead    (memRead),
    .ptWrite    (ptWrite),
    .done       (done)
  );

  mem_enum_dp #(.PageBits(PageBits), .QwBits(QwBits)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .ptSlot     (ptSlot),
    .ptData     (ptData),
    .pageCount  (pageCount),
    .pageAtTop  (pageAtTop),
    .pageAtZero (pageAtZero),
    .qwAtZero   (qwAtZero),
    .pageExists (pageExists),
    .tableFull  (tableFull),
    .fillAtEnd  (fillAtEnd)
  );
endmodule

// File: rtl/mem_enum_chk.sv
module mem_enum_chk #(
  parameter int PageBits = 12,
  parameter int QwBits   = 6,
  localparam int AddrW   = PageBits + QwBits
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                memWrite,
  input logic                memRead,
  input logic [AddrW-1:0]    memAddr,
  input logic [63:0]         memWdata,
  input logic                ptWrite,
  input logic [PageBits-1:0] ptSlot,
  input logic [15:0]         ptData,
  input logic                done,
  input logic [PageBits:0]   pageCount
);
  logic [PageBits-1:0] pg;
  logic [QwBits-1:0]   qw;
  logic                isVac;
  assign pg    = memAddr[AddrW-1:QwBits];
  assign qw    = memAddr[QwBits-1:0];
  assign isVac = (ptData == 16'h6000);

  // R2: consecutive signature writes step down one page
  p_sig_descend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memWdata != '0 && $past(memWrite && memWdata != '0))
      |-> (pg == $past(pg) - 1'b1));

  // R3
  p_no_rw_overlap_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrite && memRead));

  // R3
  p_read_first_qw_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> (qw == '0));

  // R5
  p_entry_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ptWrite && !isVac) |-> ({1'b0, ptSlot} == pageCount));

  // R6: the clear starts at the top quadword of the page just entered
  p_zero_follows_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ptWrite && !isVac) |=>
      (memWrite && memWdata == '0 && memAddr == {$past(ptData[PageBits-1:0]), {QwBits{1'b1}}}));

  // R6: the clear walks downwards through one page
  p_zero_descend_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && memWdata == '0 && !(&qw) && $past(memWrite && memWdata == '0))
      |-> (qw == $past(qw) - 1'b1 && pg == $past(pg)));

  // R7
  p_vacant_above_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ptWrite && isVac) |-> ({1'b0, ptSlot} >= pageCount));

  // R8
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memWrite && !memRead && !ptWrite));

  // R8
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(pageCount)));
endmodule

bind mem_enum mem_enum_chk #(.PageBits(PageBits), .QwBits(QwBits)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .memWrite  (memWrite),
  .memRead   (memRead),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .ptWrite   (ptWrite),
  .ptSlot    (ptSlot),
  .ptData    (ptData),
  .done      (done),
  .pageCount (pageCount)
);

// File: tb/mem_enum_tb.sv
module mem_enum_tb;
  localparam int ClkPeriod = 10;
  localparam int PB  = 5;
  localparam int PW  = 256;
  localparam int QB  = 6;
  localparam int N   = 1 << PB;
  localparam int QPP = 1 << QB;
  localparam int AW  = PB + QB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic memWrite, memRead, ptWrite, done;
  logic [AW-1:0] memAddr;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic [PB-1:0] ptSlot;
  logic [15:0] ptData;
  logic [PB:0] pageCount;

  mem_enum #(.PageBits(PB), .PageWords(PW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memWrite(memWrite), .memRead(memRead), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .ptWrite(ptWrite), .ptSlot(ptSlot), .ptData(ptData),
    .done(done), .pageCount(pageCount)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  logic [63:0] memArr [N*QPP];
  logic [N-1:0] present;
  int flipCnt [N];
  bit aliasEn;
  logic [15:0] ptTab [N];
  int ptHits [N];
  int sigErr, sigPrev;
  int total = 0;
  int bad = 0;

  function automatic logic [63:0] sigOf(int p);
    return {16'h0000, 16'hB800, 16'h00D6, 16'(p)};
  endfunction

  function automatic logic [63:0] maskOf(int k);
    if (k >= 64) return '1;
    return (64'd1 << k) - 64'd1;
  endfunction

  // memory model: missing pages read all-ones; optional aliasing of upper half onto lower
  always @(posedge clk) begin
    int p, q;
    p = int'(memAddr[AW-1:QB]);
    q = int'(memAddr[QB-1:0]);
    if (memWrite) begin
      if (present[p]) memArr[p*QPP+q] = memWdata;
      else if (aliasEn && p >= N/2 && present[p-N/2]) memArr[(p-N/2)*QPP+q] = memWdata;
      if (memWdata != '0) begin
        if (q != 0 || memWdata != sigOf(p) || (sigPrev < 0 && p != N-1) ||
            (sigPrev >= 0 && p != sigPrev - 1)) sigErr++;
        sigPrev = p;
      end
    end
    if (memRead) begin
      if (present[p]) memRdata <= memArr[p*QPP+q] ^ ((q == 0) ? maskOf(flipCnt[p]) : 64'd0);
      else            memRdata <= '1;
    end
    if (ptWrite) begin
      ptTab[ptSlot]  = ptData;
      ptHits[ptSlot] = ptHits[ptSlot] + 1;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prepare(logic [N-1:0] pres, bit al);
    present = pres;
    aliasEn = al;
    for (int i = 0; i < N*QPP; i++) memArr[i] = 64'hA5A5_0000_0000_0000 | 64'(i + 1);
    for (int i = 0; i < N; i++) begin
      flipCnt[i] = 0;
      ptTab[i]   = 16'hFFFF;
      ptHits[i]  = 0;
    end
    sigErr  = 0;
    sigPrev = -1;
  endtask

  function automatic bit inTable(int p, int e);
    for (int s = 0; s < e; s++) if (ptTab[s] == 16'(p)) return 1'b1;
    return 1'b0;
  endfunction

  // runs one enumeration and checks everything the requirements predict
  task automatic runAndCheck(string tag, bit poke, output int eOut);
    int exp [$];
    int e, k, lat;
    bit zok;
    for (int p = 0; p < N; p++) if (present[p] && flipCnt[p] < 4) exp.push_back(p);
    e = exp.size();
    eOut = e;
    lat = 5*N + 63*e;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (!done && k < lat + 50) begin
      @(negedge clk);
      k++;
      if (poke && k == 40) start = 1'b1;
      if (poke && k == 41) start = 1'b0;
    end
    check(k == lat, poke ? "R11" : "R9", {tag, " cycles to done"}, k, lat);
    check(pageCount == (PB+1)'(e), "R8", {tag, " page count"}, pageCount, e);
    check(sigErr == 0, "R2", {tag, " signature order/content errors"}, sigErr, 0);
    for (int s = 0; s < N; s++) begin
      if (s < e) check(ptTab[s] == 16'(exp[s]), "R5", {tag, " slot entry"}, ptTab[s], exp[s]);
      else       check(ptTab[s] == 16'h6000, "R7", {tag, " vacant slot"}, ptTab[s], 16'h6000);
      check(ptHits[s] == 1, "R7", {tag, " slot write count"}, ptHits[s], 1);
    end
    for (int i = 0; i < e; i++) begin
      zok = 1'b1;
      for (int q = 0; q < QPP; q++) if (memArr[exp[i]*QPP+q] != '0) zok = 1'b0;
      check(zok, "R6", {tag, " page cleared"}, exp[i], exp[i]);
    end
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(done && pageCount == (PB+1)'(e), "R8", {tag, " done held"}, pageCount, e);
    end
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(pageCount == '0, "R1", "count after reset", pageCount, 0);
    check(!memWrite && !memRead && !ptWrite, "R1", "strobes after reset",
          {memWrite, memRead, ptWrite}, 0);
  endtask

  task automatic testAllPresent();
    int e;
    prepare('1, 1'b0);
    runAndCheck("all-present", 1'b0, e);
    check(e == N, "R4", "all pages found", e, N);
  endtask

  task automatic testHolesAndFaults();
    int e;
    logic [N-1:0] pres;
    pres = '1;
    pres[2] = 1'b0; pres[11] = 1'b0; pres[20] = 1'b0; pres[21] = 1'b0; pres[30] = 1'b0;
    prepare(pres, 1'b1);
    flipCnt[3] = 1; flipCnt[12] = 2; flipCnt[5] = 3; flipCnt[7] = 4; flipCnt[9] = 60;
    runAndCheck("holes", 1'b0, e);
    check(e == 25, "R4", "holes count", e, 25);
    check(inTable(5, e), "R4", "three-bit page kept", 0, 5);
    check(!inTable(7, e), "R4", "four-bit page dropped", 7, 0);
    check(!inTable(11, e), "R4", "all-ones page dropped", 11, 0);
    check(inTable(4, e) && inTable(14, e), "R10", "aliased lower pages found", 0, 1);
  endtask

  task automatic testNonePresent();
    int e;
    prepare('0, 1'b0);
    runAndCheck("empty", 1'b0, e);
    check(e == 0, "R7", "empty count", e, 0);
  endtask

  task automatic testBusyStart();
    int e;
    logic [N-1:0] pres;
    pres = '0;
    pres[N/2-1:0] = '1;
    prepare(pres, 1'b1);
    runAndCheck("busy-start", 1'b1, e);
    check(e == N/2, "R10", "lower half with aliasing", e, N/2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    present = '0;
    aliasEn = 1'b0;
    for (int i = 0; i < N; i++) flipCnt[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllPresent();
    testHolesAndFaults();
    testNonePresent();
    testBusyStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule